// File: doc/BRIEF.md
# Indexed Color Palette Port

This block gives a CPU byte-wide access to a small color palette RAM that is split into two halves, one for background colors and one for object colors. Each half is reached through a pair of registers. The pointer register selects a byte in that half and holds a flag that steps the pointer forward after each data write. The data register reads or writes the byte the pointer selects. Software sets the pointer once with the step flag on, then streams a whole palette through the data register.

A second, independent read port lets a downstream renderer fetch any palette byte by its absolute address, with the result in the same cycle. A compatibility input shuts the CPU side off. In that mode writes are dropped and every register read returns all ones.

Top module: `palette_port`

## Requirements
- R1: After reset every palette byte is 0x00, and both pointer registers read 0x00.
- R2: Writing a pointer register (select 2'b00 background, 2'b10 object) stores the written byte with bit 6 forced to 0. Bits 5:0 are the byte index and bit 7 is the step flag, and the register reads back in that layout.
- R3: Right after a pointer write, the data register of the same half (select 2'b01 background, 2'b11 object) reads the palette byte at the new index.
- R4: A data-register write stores the byte at the current index of its half. The background half sits at absolute addresses 0–63 and the object half at 64–127.
- R5: A data write made while the step flag is 1 advances the index by one. The index wraps from 63 to 0, and the flag stays set.
- R6: A data write made while the step flag is 0 leaves the pointer unchanged.
- R7: Reading a data register returns the byte at the current index and leaves the pointer unchanged.
- R8: While the compatibility input is high, register writes change neither the palette nor the pointers.
- R9: While the compatibility input is high, every register read returns 0xFF.
- R10: The renderer port returns the palette byte at its 7-bit absolute address in the same cycle, whatever the CPU side is doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| monoMode | input | 1 | Compatibility mode: CPU writes dropped, reads all ones |
| regSel | input | 2 | Register select: bit 1 picks the object half, bit 0 picks the data register |
| regWr | input | 1 | Write strobe for the selected register |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of the selected register (combinational) |
| renderAddr | input | 7 | Renderer absolute palette address |
| renderData | output | 8 | Palette byte at renderAddr (combinational) |

## Verification
The bench builds the block with its default widths: a 6-bit index and 8-bit bytes, which gives 64 bytes per half and 128 in all. At that size a few thousand random operations reach every index and both wrap points many times. A pointer set to 63 with the step flag on is driven through a data write, so the 63-to-0 wrap in each half is reached directly. The object half's offset of 64 shows up on the renderer port, and a pointer write with bit 6 set shows the masking.

// File: rtl/palette_pkg.sv
`timescale 1ns/1ps
package palette_pkg;
  localparam int NUM_SIDES = 2;

  typedef enum logic [1:0] {
    SEL_BG_IDX   = 2'b00,
    SEL_BG_DATA  = 2'b01,
    SEL_OBJ_IDX  = 2'b10,
    SEL_OBJ_DATA = 2'b11
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_SIDES-1:0] idxWr;
    logic [NUM_SIDES-1:0] dataWr;
    logic                 rdBlank;
  } strobe_t;
endpackage

// File: rtl/palette_ctrl.sv
`timescale 1ns/1ps
module palette_ctrl
  import palette_pkg::*;
(
  input  logic       monoMode,
  input  logic [1:0] regSel,
  input  logic       regWr,
  output strobe_t    stb
);
  always_comb begin
    stb = '0;
    stb.rdBlank = monoMode;
    if (regWr && !monoMode) begin
      unique case (regSel_e'(regSel))
        SEL_BG_IDX:   stb.idxWr[0]  = 1'b1;
        SEL_BG_DATA:  stb.dataWr[0] = 1'b1;
        SEL_OBJ_IDX:  stb.idxWr[1]  = 1'b1;
        SEL_OBJ_DATA: stb.dataWr[1] = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/palette_dp.sv
`timescale 1ns/1ps
module palette_dp
  import palette_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       stb,
  input  logic [DATA_W-1:0]             wrData,
  input  logic [1:0]                    rdSel,
  input  logic [IDX_W:0]                renderAddr,
  output logic [DATA_W-1:0]             rdData,
  output logic [DATA_W-1:0]             renderData,
  output logic [NUM_SIDES-1:0][IDX_W:0] idxView
);
  localparam int SIDE_BYTES = 1 << IDX_W;
  localparam int DEPTH      = NUM_SIDES * SIDE_BYTES;
  localparam int PAD_W      = DATA_W - IDX_W - 1;

  logic [NUM_SIDES-1:0][IDX_W:0] idxQ;   // {stepFlag, index}
  logic [DATA_W-1:0]             palMem [DEPTH];

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        idxQ[s] <= '0;
      else if (stb.idxWr[s])
        idxQ[s] <= {wrData[DATA_W-1], wrData[IDX_W-1:0]};
      else if (stb.dataWr[s] && idxQ[s][IDX_W])
        idxQ[s][IDX_W-1:0] <= idxQ[s][IDX_W-1:0] + 1'b1;
    end
  end

  logic             wrEn;
  logic             wrSide;
  logic [IDX_W:0]   wrAddr;
  assign wrEn   = |stb.dataWr;
  assign wrSide = stb.dataWr[1];
  assign wrAddr = {wrSide, idxQ[wrSide][IDX_W-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) palMem[i] <= '0;
    end else if (wrEn) begin
      palMem[wrAddr] <= wrData;
    end
  end

  logic            rdSide;
  logic [IDX_W:0]  rdPtr;
  logic [DATA_W-1:0] ptrByte;
  assign rdSide  = rdSel[1];
  assign rdPtr   = idxQ[rdSide];
  assign ptrByte = {rdPtr[IDX_W], {PAD_W{1'b0}}, rdPtr[IDX_W-1:0]};

  always_comb begin
    if (stb.rdBlank)
      rdData = '1;
    else if (rdSel[0])
      rdData = palMem[{rdSide, rdPtr[IDX_W-1:0]}];
    else
      rdData = ptrByte;
  end

  assign renderData = palMem[renderAddr];
  assign idxView    = idxQ;
endmodule

// File: rtl/palette_port.sv
`timescale 1ns/1ps
module palette_port
  import palette_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              monoMode,
  input  logic [1:0]        regSel,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [IDX_W:0]    renderAddr,
  output logic [DATA_W-1:0] renderData
);
  strobe_t                       stb;
  logic [NUM_SIDES-1:0][IDX_W:0] idxView;

  palette_ctrl u_ctrl (
    .monoMode (monoMode),
    .regSel   (regSel),
    .regWr    (regWr),
    .stb      (stb)
  );

  palette_dp #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wrData     (regWrData),
    .rdSel      (regSel),
    .renderAddr (renderAddr),
    .rdData     (regRdData),
    .renderData (renderData),
    .idxView    (idxView)
  );
endmodule

// File: rtl/palette_port_chk.sv
`timescale 1ns/1ps
module palette_port_chk #(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              monoMode,
  input logic [1:0]        regSel,
  input logic              regWr,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic [1:0][IDX_W:0] idxView
);
  AST_MONO_READ_ONES: assert property (@(posedge clk) disable iff (!rstN)
    monoMode |-> (regRdData == {DATA_W{1'b1}})); // R9

  AST_MONO_PTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    monoMode |=> $stable(idxView)); // R8

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && !monoMode && !regSel[0]) |=>
      idxView[$past(regSel[1])] == {$past(regWrData[DATA_W-1]), $past(regWrData[IDX_W-1:0])}); // R2

  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && !monoMode && regSel[0] && idxView[regSel[1]][IDX_W]) |=>
      idxView[$past(regSel[1])] == {1'b1, $past(idxView[regSel[1]][IDX_W-1:0]) + 1'b1}); // R5

  AST_NO_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && !monoMode && regSel[0] && !idxView[regSel[1]][IDX_W]) |=> $stable(idxView)); // R6

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !regWr |=> $stable(idxView)); // R7
endmodule

bind palette_port palette_port_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .monoMode  (monoMode),
  .regSel    (regSel),
  .regWr     (regWr),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .idxView   (idxView)
);

// File: tb/palette_port_tb.sv
`timescale 1ns/1ps
module palette_port_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       monoMode = 1'b0;
  logic [1:0] regSel = 2'b00;
  logic       regWr = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic [6:0] renderAddr = 7'd0;
  logic [7:0] renderData;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic [7:0] mdlPal [128];
  logic [5:0] mdlIdx [2];
  logic       mdlInc [2];

  always #2 clk = ~clk;

  palette_port u_dut (
    .clk(clk), .rstN(rstN), .monoMode(monoMode), .regSel(regSel),
    .regWr(regWr), .regWrData(regWrData), .regRdData(regRdData),
    .renderAddr(renderAddr), .renderData(renderData)
  );

  function automatic logic [7:0] expRead(input logic [1:0] sel, input logic mono);
    if (mono) return 8'hFF;
    if (sel[0]) return mdlPal[{sel[1], mdlIdx[sel[1]]}];
    return {mdlInc[sel[1]], 1'b0, mdlIdx[sel[1]]};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // one register operation, then probe every register and the render port
  task automatic doOp(input logic [1:0] sel, input logic wr, input logic [7:0] d,
                      input logic mono, input logic [6:0] rAddr);
    logic s;
    @(negedge clk);
    regSel = sel; regWr = wr; regWrData = d; monoMode = mono;
    @(posedge clk);
    #0.5;
    regWr = 1'b0;
    s = sel[1];
    if (wr && !mono) begin
      if (!sel[0]) begin
        mdlIdx[s] = d[5:0];
        mdlInc[s] = d[7];
      end else begin
        mdlPal[{s, mdlIdx[s]}] = d;
        if (mdlInc[s]) mdlIdx[s] = mdlIdx[s] + 6'd1;
      end
    end
    for (int k = 0; k < 4; k++) begin
      regSel = 2'(k);
      #0.3;
      if (mono)        chk("R9", regRdData, expRead(2'(k), mono));
      else if (k[0])   chk("R3", regRdData, expRead(2'(k), mono));
      else             chk("R2", regRdData, expRead(2'(k), mono));
    end
    renderAddr = rAddr;
    #0.2;
    chk("R10", renderData, mdlPal[rAddr]);
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'h5EED_1234);
    for (int i = 0; i < 128; i++) mdlPal[i] = 8'h00;
    for (int s = 0; s < 2; s++) begin mdlIdx[s] = '0; mdlInc[s] = 1'b0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    for (int k = 0; k < 4; k++) begin
      regSel = 2'(k); #0.3;
      chk("R1", regRdData, 8'h00);
    end
    renderAddr = 7'd100; #0.2;
    chk("R1", renderData, 8'h00);

    // R2: bit 6 masked
    doOp(2'b00, 1'b1, 8'hFF, 1'b0, 7'd0);
    regSel = 2'b00; #0.2;
    chk("R2", regRdData, 8'hBF);
    // R5: wrap 63 -> 0 with flag kept
    doOp(2'b01, 1'b1, 8'h5A, 1'b0, 7'd63);
    regSel = 2'b00; #0.2;
    chk("R5", regRdData, 8'h80);
    renderAddr = 7'd63; #0.2;
    chk("R4", renderData, 8'h5A);
    // R4: object half at offset 64, wrap there too
    doOp(2'b10, 1'b1, 8'hBF, 1'b0, 7'd0);
    doOp(2'b11, 1'b1, 8'hC3, 1'b0, 7'd127);
    renderAddr = 7'd127; #0.2;
    chk("R4", renderData, 8'hC3);
    regSel = 2'b10; #0.2;
    chk("R5", regRdData, 8'h80);
    // R6: no step without flag
    doOp(2'b00, 1'b1, 8'h05, 1'b0, 7'd5);
    doOp(2'b01, 1'b1, 8'h77, 1'b0, 7'd5);
    regSel = 2'b00; #0.2;
    chk("R6", regRdData, 8'h05);
    // R7: repeated data reads leave pointer alone
    doOp(2'b01, 1'b0, 8'h00, 1'b0, 7'd5);
    doOp(2'b01, 1'b0, 8'h00, 1'b0, 7'd5);
    regSel = 2'b00; #0.2;
    chk("R7", regRdData, 8'h05);
    // R8: writes dropped in compatibility mode
    doOp(2'b01, 1'b1, 8'hEE, 1'b1, 7'd5);
    doOp(2'b00, 1'b1, 8'h20, 1'b1, 7'd5);
    monoMode = 1'b0;
    regSel = 2'b01; #0.2;
    chk("R8", regRdData, 8'h77);
    regSel = 2'b00; #0.2;
    chk("R8", regRdData, 8'h05);

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] sel;
      logic       wr, mono;
      logic [7:0] d;
      sel  = 2'($urandom_range(0, 3));
      wr   = ($urandom_range(0, 3) != 0);
      mono = ($urandom_range(0, 9) == 0);
      d    = 8'($urandom);
      if (!sel[0] && ($urandom_range(0, 3) == 0)) d[5:0] = 6'd62 + 6'($urandom_range(0, 1));
      doOp(sel, wr, d, mono, 7'($urandom_range(0, 127)));
    end
    done = 1'b1;
    report();
  end
endmodule